// File: doc/BRIEF.md
# SPI Slave Register Port

This block lets an external host read and write a bank of 16-bit configuration registers over a four-wire SPI link in which the block is always the slave. Every transaction sent while slave select is low has 24 bits, most significant first: a direction bit, a 7-bit register address and a 16-bit data word. While the direction bit and the address are still coming in, the block sends an 8-bit status byte, taken from an input port, back to the host on MISO. On a read, MISO then carries the 16 bits of the addressed register.

The SPI pins are asynchronous to the block clock. They pass through synchronizers and the block acts on the edges it sees in the clock domain, so the SPI clock must be several times slower than the block clock. A strap input selects one of two MISO timings. A write reaches the register bank only when slave select rises, and only if the transaction had exactly 24 SPI clocks. The register bank sits outside the block and has a combinational read port.

Top module: `spi_reg_slave`

## Requirements
- R1: A frame is sent MSB first: the direction bit, then address bits 6 down to 0, then data bits 15 down to 0, each sampled on a rising SPI clock. A direction bit of 0 means write and 1 means read.
- R2: A write frame with exactly 24 rising SPI clocks makes `regWe` high for exactly one block clock after slave select rises, with `regAddr` and `regWdata` holding the address and data of the frame. A read frame makes no write pulse.
- R3: A frame with any other number of rising SPI clocks (fewer or more than 24) makes no write pulse and leaves the register bank unchanged.
- R4: During the first 8 bits of each frame MISO carries the `status` value captured when slave select fell, bit 7 first.
- R5: On a read frame, bits 9 to 24 on MISO are bits 15 down to 0 of the register at the frame's address.
- R6: With `cpha` = 0, status bit 7 is on MISO before the first rising SPI clock, and MISO moves to the next bit after each falling SPI clock, so the host samples on rising edges.
- R7: With `cpha` = 1, MISO holds each bit from one rising SPI clock to the next: status bit 7 is shown after the first rising edge, and the host samples on falling edges.
- R8: While slave select is high, toggling the SPI clock or MOSI changes neither `regAddr` nor `regWdata` and makes no write pulse.
- R9: MISO is high-impedance whenever slave select is high.
- R10: After reset, `regWe` is low and MISO is high-impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpha | input | 1 | Strap that selects the MISO timing (0 or 1) |
| spiSclk | input | 1 | SPI clock from the host, idle low |
| spiSsN | input | 1 | Slave select, active low |
| spiMosi | input | 1 | Serial data from the host |
| spiMiso | output | 1 | Serial data to the host; high-impedance when not selected |
| status | input | 8 | Status byte returned at the start of each frame |
| regAddr | output | 7 | Register bank address |
| regWdata | output | 16 | Register bank write data |
| regWe | output | 1 | Register bank write strobe, one clock wide |
| regRdata | input | 16 | Register bank read data, combinational from `regAddr` |

## Verification
An SPI pin edge takes effect in the registers three block clocks after it (two synchronizer stages and one edge-detect stage). So a MISO bit moves three clocks after the SPI clock edge that shifts it, and the write strobe comes three clocks after slave select rises. The bench holds each SPI clock level for six block clocks and samples MISO just before the next edge the host would use. It drives every pin on the falling block clock and tracks write pulses with a monitor on the rising edge, counting them and logging the address and data of each pulse. Each write check is made after slave select has been high for six clocks, and the read-back checks compare MISO bits taken at those sample points against the values the bench wrote earlier.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  // Strobes from the control FSM to the datapath, one block clock wide unless noted
  typedef struct packed {
    logic loadStat;  // frame start: capture the status byte
    logic shIn;      // rising SPI clock: shift MOSI in
    logic inCmd;     // level: incoming bit belongs to the command byte
    logic shOut;     // advance MISO by one bit
    logic outData;   // level: MISO now comes from the read word
    logic loadRd;    // address complete: capture register read data
    logic commit;    // frame end on a valid write: strobe the bank
    logic misoOe;    // level: slave selected, drive MISO
  } spiStrobe_t;

endpackage

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpha,
  input  logic       spiSclk,
  input  logic       spiSsN,
  input  logic       spiMosi,
  output logic       mosiBit,
  output spiStrobe_t stb
);

  localparam int CMD_W   = ADDR_W + 1;
  localparam int FRAME_W = CMD_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FRAME = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_CMD   = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(CMD_W - 1);

  // Pin synchronizers
  logic [SYNC_DEPTH-1:0] sclkSync, ssSync, mosiSync;
  logic sclkPrev, ssPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      ssSync   <= '1;
      mosiSync <= '0;
      sclkPrev <= 1'b0;
      ssPrev   <= 1'b1;
    end else begin
      sclkSync <= {sclkSync[SYNC_DEPTH-2:0], spiSclk};
      ssSync   <= {ssSync[SYNC_DEPTH-2:0], spiSsN};
      mosiSync <= {mosiSync[SYNC_DEPTH-2:0], spiMosi};
      sclkPrev <= sclkSync[SYNC_DEPTH-1];
      ssPrev   <= ssSync[SYNC_DEPTH-1];
    end
  end

  logic sclkNow, ssNow;
  assign sclkNow = sclkSync[SYNC_DEPTH-1];
  assign ssNow   = ssSync[SYNC_DEPTH-1];
  assign mosiBit = mosiSync[SYNC_DEPTH-1];

  logic ssFallEv, ssRiseEv, sclkRiseEv, sclkFallEv;
  assign ssFallEv   = ssPrev & ~ssNow;
  assign ssRiseEv   = ~ssPrev & ssNow;
  assign sclkRiseEv = ~ssNow & sclkNow & ~sclkPrev;
  assign sclkFallEv = ~ssNow & ~sclkNow & sclkPrev;

  // Bit counters
  logic [CNT_W-1:0] rxCnt, outCnt;
  logic             rwBit, rdPend, outShift;

  assign outShift = cpha ? (sclkRiseEv && rxCnt != '0) : sclkFallEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxCnt  <= '0;
      outCnt <= '0;
      rwBit  <= 1'b1;
      rdPend <= 1'b0;
    end else begin
      rdPend <= sclkRiseEv && (rxCnt == CNT_LAST);
      if (ssFallEv) begin
        rxCnt  <= '0;
        outCnt <= '0;
      end else begin
        if (sclkRiseEv && rxCnt != CNT_SAT) rxCnt <= rxCnt + 1'b1;
        if (outShift && outCnt != CNT_FRAME) outCnt <= outCnt + 1'b1;
      end
      if (sclkRiseEv && rxCnt == '0) rwBit <= mosiBit;
    end
  end

  always_comb begin
    stb          = '0;
    stb.loadStat = ssFallEv;
    stb.shIn     = sclkRiseEv;
    stb.inCmd    = rxCnt < CNT_CMD;
    stb.shOut    = outShift;
    stb.outData  = outCnt >= CNT_CMD;
    stb.loadRd   = rdPend;
    stb.commit   = ssRiseEv && (rxCnt == CNT_FRAME) && !rwBit;
    stb.misoOe   = ~ssNow;
  end

  // R8
  frozen_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ssNow |=> $stable(rxCnt));
  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxCnt <= CNT_SAT);
  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> !stb.commit);
  // R5
  read_load_point_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdPend |-> rxCnt == CNT_CMD);

endmodule

// File: rtl/spi_reg_dp.sv
module spi_reg_dp
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  spiStrobe_t              stb,
  input  logic                    mosiBit,
  input  logic [ADDR_W:0]         status,
  input  logic [DATA_W-1:0]       regRdata,
  output logic [ADDR_W-1:0]       regAddr,
  output logic [DATA_W-1:0]       regWdata,
  output logic                    regWe,
  output logic                    misoBit,
  output logic                    misoOe
);

  localparam int CMD_W = ADDR_W + 1;

  logic [CMD_W-1:0]  cmdReg, statSh;
  logic [DATA_W-1:0] dataIn, dataSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= '0;
      dataIn <= '0;
    end else if (stb.shIn) begin
      if (stb.inCmd) cmdReg <= {cmdReg[CMD_W-2:0], mosiBit};
      else           dataIn <= {dataIn[DATA_W-2:0], mosiBit};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statSh <= '0;
      dataSh <= '0;
    end else begin
      if (stb.loadStat)                      statSh <= status;
      else if (stb.shOut && !stb.outData)    statSh <= {statSh[CMD_W-2:0], 1'b0};
      if (stb.loadRd)                        dataSh <= regRdata;
      else if (stb.shOut && stb.outData)     dataSh <= {dataSh[DATA_W-2:0], 1'b0};
    end
  end

  assign misoBit  = stb.outData ? dataSh[DATA_W-1] : statSh[CMD_W-1];
  assign misoOe   = stb.misoOe;
  assign regAddr  = cmdReg[ADDR_W-1:0];
  assign regWdata = dataIn;
  assign regWe    = stb.commit;

  // R2
  write_is_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> !cmdReg[CMD_W-1]);
  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !misoOe |=> $stable(cmdReg) && $stable(dataIn));

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpha,
  input  logic              spiSclk,
  input  logic              spiSsN,
  input  logic              spiMosi,
  output logic              spiMiso,
  input  logic [ADDR_W:0]   status,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  input  logic [DATA_W-1:0] regRdata
);

  spiStrobe_t stb;
  logic       mosiBit, misoBit, misoOe;

  spi_reg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_DEPTH(SYNC_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpha(cpha), .spiSclk(spiSclk), .spiSsN(spiSsN),
    .spiMosi(spiMosi), .mosiBit(mosiBit), .stb(stb)
  );

  spi_reg_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .mosiBit(mosiBit), .status(status),
    .regRdata(regRdata), .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe),
    .misoBit(misoBit), .misoOe(misoOe)
  );

  assign spiMiso = misoOe ? misoBit : 1'bz;

endmodule

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb;

  localparam int H = 6;  // block clocks per SPI clock level

  logic        clk = 1'b0, rstN = 1'b0, cpha = 1'b0;
  logic        spiSclk = 1'b0, spiSsN = 1'b1, spiMosi = 1'b0;
  wire         spiMiso;
  logic [7:0]  status = 8'h00;
  logic [6:0]  regAddr;
  logic [15:0] regWdata, regRdata;
  logic        regWe;

  always #5 clk = ~clk;

  spi_reg_slave u_dut (
    .clk(clk), .rstN(rstN), .cpha(cpha), .spiSclk(spiSclk), .spiSsN(spiSsN),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .status(status), .regAddr(regAddr),
    .regWdata(regWdata), .regWe(regWe), .regRdata(regRdata)
  );

  // Register bank model and write monitor
  logic [15:0] mem [128];
  int          weCount = 0;
  logic [6:0]  lastA = '0;
  logic [15:0] lastD = '0;
  initial for (int i = 0; i < 128; i++) mem[i] = 16'h0000;
  assign regRdata = mem[regAddr];
  always @(posedge clk) if (rstN && regWe) begin
    weCount <= weCount + 1;
    lastA   <= regAddr;
    lastD   <= regWdata;
    mem[regAddr] <= regWdata;
  end

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spiXfer(input logic rwI, input logic [6:0] a, input logic [15:0] d,
                         input int nclk, output logic [23:0] got);
    logic [23:0] frame;
    frame = {rwI, a, d};
    got = '0;
    @(negedge clk) spiSsN = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      spiMosi = (i < 24) ? frame[23-i] : 1'b0;
      repeat (H) @(negedge clk);
      if (!cpha && i < 24) got[23-i] = spiMiso;
      spiSclk = 1'b1;
      repeat (H) @(negedge clk);
      if (cpha && i < 24) got[23-i] = spiMiso;
      spiSclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    spiSsN = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  typedef struct packed {
    logic        rw;
    logic        ph;
    logic [6:0]  a;
    logic [15:0] d;
    logic [7:0]  st;
    logic [15:0] expRd;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 1'b0, 7'h05, 16'hA5C3, 8'h3C, 16'h0000},
    '{1'b0, 1'b1, 7'h7F, 16'h1234, 8'h81, 16'h0000},
    '{1'b1, 1'b0, 7'h05, 16'h0000, 8'hE7, 16'hA5C3},
    '{1'b1, 1'b1, 7'h7F, 16'h0000, 8'h5A, 16'h1234},
    '{1'b1, 1'b0, 7'h00, 16'h0000, 8'h00, 16'h0000},
    '{1'b0, 1'b0, 7'h00, 16'hFFFF, 8'hFF, 16'h0000},
    '{1'b1, 1'b1, 7'h00, 16'h0000, 8'h42, 16'hFFFF}
  };

  initial begin
    logic [23:0] got;
    int          weBefore;
    logic [6:0]  aHold;
    logic [15:0] dHold;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 regWe in reset", {31'd0, regWe}, 32'd0);
    chk("R10 MISO in reset", {31'd0, spiMiso === 1'bz}, 32'd1);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 MISO idle", {31'd0, spiMiso === 1'bz}, 32'd1);

    // Table walk: R1 R2 R4 R5 R6 R7
    foreach (VECS[k]) begin
      status   = VECS[k].st;
      cpha     = VECS[k].ph;
      weBefore = weCount;
      spiXfer(VECS[k].rw, VECS[k].a, VECS[k].d, 24, got);
      chk(VECS[k].ph ? "R4 R7 status byte" : "R4 R6 status byte",
          {24'd0, got[23:16]}, {24'd0, VECS[k].st});
      if (!VECS[k].rw) begin
        chk("R2 one write pulse", weCount, weBefore + 1);
        chk("R1 write address", {25'd0, lastA}, {25'd0, VECS[k].a});
        chk("R1 write data", {16'd0, lastD}, {16'd0, VECS[k].d});
      end else begin
        chk(VECS[k].ph ? "R5 R7 read data" : "R5 R6 read data",
            {16'd0, got[15:0]}, {16'd0, VECS[k].expRd});
        chk("R2 no write on read", weCount, weBefore);
      end
      chk("R9 MISO released", {31'd0, spiMiso === 1'bz}, 32'd1);
    end

    // R3 short write frame
    cpha = 1'b0; status = 8'h11;
    weBefore = weCount;
    spiXfer(1'b0, 7'h05, 16'h0BAD, 20, got);
    chk("R3 short frame no write", weCount, weBefore);
    // R3 long write frame
    spiXfer(1'b0, 7'h05, 16'h0BAD, 25, got);
    chk("R3 long frame no write", weCount, weBefore);
    spiXfer(1'b1, 7'h05, 16'h0000, 24, got);
    chk("R3 register unchanged", {16'd0, got[15:0]}, 32'h0000A5C3);

    // R8 SPI activity while deselected
    aHold = regAddr; dHold = regWdata; weBefore = weCount;
    for (int i = 0; i < 10; i++) begin
      spiMosi = i[0];
      spiSclk = 1'b1; repeat (H) @(negedge clk);
      spiSclk = 1'b0; repeat (H) @(negedge clk);
    end
    chk("R8 address held", {25'd0, regAddr}, {25'd0, aHold});
    chk("R8 data held", {16'd0, regWdata}, {16'd0, dHold});
    chk("R8 no write", weCount, weBefore);
    chk("R9 MISO idle under clocking", {31'd0, spiMiso === 1'bz}, 32'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule